// File: doc/BRIEF.md
# Address-Space-Tagged Translation Buffer with Table Refill

This block translates 16-bit virtual addresses into physical addresses for one requester. It holds a small fully associative set of cached translations. Each cached translation is tagged with the address space identifier (ASID) of the process that loaded it, so translations from several processes can stay resident across context switches. A request carries a virtual address, an access kind and the current ASID. It is accepted through a valid/ready handshake. A single-cycle response pulse reports the outcome.

On a hit the block either returns the physical address or reports a protection fault. On a miss it reads one 32-bit entry from a linear page table in memory through a read port with a request handshake and a response strobe. It then reports a segmentation fault, reports a protection fault, or installs the entry and asks the requester to retry. Software can drop every cached translation, or only those of one ASID.

Top module: `tlb_asid_refill`

## Requirements
- R1: The virtual page number is `req_vaddr[15:8]` and the page offset is `req_vaddr[7:0]`. On a permitted hit the response status is OK (code 0) and `rsp_paddr = {pfn, offset}`.
- R2: A hit produces `rsp_valid` in the cycle after the request is accepted, and it makes no memory read.
- R3: A cached translation matches only if it is valid and both its page number and its ASID equal the request's. The same page under a different ASID is a miss.
- R4: Access codes are 0 = read, 1 = write, 2 = execute, and 3 = never permitted. A hit whose permissions forbid the access reports status PROT (code 3) with `rsp_paddr` zero, and it makes no memory read.
- R5: A miss issues exactly one memory read at `ptbr + 4*vpn`. The returned word has bit 31 = valid, bit 30 = read, bit 29 = write, bit 28 = execute, and bits 7:0 = frame number. The read address is held while the request waits for `mem_req_ready`.
- R6: If the fetched entry is invalid, the status is SEGV (code 2) and nothing is cached. A repeat of the request misses again.
- R7: If the fetched entry is valid but forbids the access, the status is PROT (code 3) and nothing is cached.
- R8: Otherwise the entry is cached with the request's ASID and the status is RETRY (code 1). The repeated request then hits.
- R9: A new translation goes into the lowest-numbered empty slot. When all 8 slots are full, slots are replaced in round-robin order starting at slot 0, and the pointer advances only on such a replacement.
- R10: `flush_all` empties every slot one cycle later. `req_ready` is low while any flush input is high.
- R11: `flush_asid_en` empties only the slots tagged with `flush_asid`. All other slots stay usable.
- R12: After reset, `req_ready` is high, `rsp_valid` and `mem_req_valid` are low, and every slot is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Block can accept a request |
| req_vaddr | input | 16 | Virtual address |
| req_acc | input | 2 | Access kind (0 read, 1 write, 2 execute, 3 none) |
| req_asid | input | 8 | ASID of the requesting process |
| ptbr | input | 16 | Physical base address of the linear page table |
| flush_all | input | 1 | Drop every cached translation |
| flush_asid_en | input | 1 | Drop the translations of one ASID |
| flush_asid | input | 8 | ASID to drop |
| mem_req_valid | output | 1 | Page-table read request |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | 16 | Page-table entry address |
| mem_rsp_valid | input | 1 | Read data returned |
| mem_rsp_data | input | 32 | Page-table entry word |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_status | output | 2 | 0 OK, 1 RETRY, 2 SEGV, 3 PROT |
| rsp_paddr | output | 16 | Physical address (zero unless OK) |

## Verification
A corrupted slot tag shows up immediately as the wrong status or the wrong read count: a stale ASID or page number turns an expected hit into an extra memory read, and a lost valid bit does the same. A wrong frame or permission field shows up on the first hit to that slot, as a wrong physical address or a wrong OK/PROT decision. A misplaced replacement pointer only becomes visible once the buffer is full, when the next refill evicts the wrong page. The bench therefore checks which page misses right after the ninth and tenth installs.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

    typedef enum logic [1:0] {
        ACC_READ  = 2'd0,
        ACC_WRITE = 2'd1,
        ACC_EXEC  = 2'd2,
        ACC_NONE  = 2'd3
    } acc_e;

    typedef enum logic [1:0] {
        RS_OK    = 2'd0,
        RS_RETRY = 2'd1,
        RS_SEGV  = 2'd2,
        RS_PROT  = 2'd3
    } rsp_e;

    typedef enum logic [1:0] {
        FS_IDLE  = 2'd0,
        FS_FETCH = 2'd1,
        FS_WAIT  = 2'd2
    } fsm_e;

    typedef struct packed {
        logic rd;
        logic wr;
        logic ex;
    } perm_t;

    function automatic logic perm_ok(perm_t p, logic [1:0] acc);
        case (acc)
            ACC_READ:  return p.rd;
            ACC_WRITE: return p.wr;
            ACC_EXEC:  return p.ex;
            default:   return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/tlb_victim_sel.sv
module tlb_victim_sel #(
    parameter int ENTRIES = 8,
    localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ENTRIES-1:0] valid_i,
    input  logic               alloc_i,
    output logic [IDX_W-1:0]   victim_o
);

    typedef struct packed {
        logic [IDX_W-1:0] ptr;
    } vs_t;

    vs_t              s_d, s_q;
    logic             free_found;
    logic [IDX_W-1:0] free_idx;

    always_comb begin
        free_found = 1'b0;
        free_idx   = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (!valid_i[i]) begin
                free_found = 1'b1;
                free_idx   = IDX_W'(i);
            end
        end
        victim_o = free_found ? free_idx : s_q.ptr;

        s_d = s_q;
        if (alloc_i && !free_found) begin
            s_d.ptr = (s_q.ptr == IDX_W'(ENTRIES - 1)) ? '0 : s_q.ptr + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

endmodule

// File: rtl/tlb_cam.sv
module tlb_cam
    import tlb_pkg::*;
#(
    parameter int ENTRIES = 8,
    parameter int VPN_W   = 8,
    parameter int PFN_W   = 8,
    parameter int ASID_W  = 8,
    localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [VPN_W-1:0]   lk_vpn_i,
    input  logic [ASID_W-1:0]  lk_asid_i,
    output logic               lk_hit_o,
    output logic [PFN_W-1:0]   lk_pfn_o,
    output perm_t              lk_perm_o,
    input  logic               flush_all_i,
    input  logic               flush_asid_en_i,
    input  logic [ASID_W-1:0]  flush_asid_i,
    input  logic               ins_en_i,
    input  logic [IDX_W-1:0]   ins_idx_i,
    input  logic [VPN_W-1:0]   ins_vpn_i,
    input  logic [PFN_W-1:0]   ins_pfn_i,
    input  perm_t              ins_perm_i,
    input  logic [ASID_W-1:0]  ins_asid_i,
    output logic [ENTRIES-1:0] valid_o
);

    typedef struct packed {
        logic [ENTRIES-1:0]             vld;
        logic [ENTRIES-1:0][VPN_W-1:0]  vpn;
        logic [ENTRIES-1:0][PFN_W-1:0]  pfn;
        logic [ENTRIES-1:0][ASID_W-1:0] asid;
        logic [ENTRIES-1:0][2:0]        perm;
    } cam_t;

    cam_t               s_d, s_q;
    logic [ENTRIES-1:0] hit_vec;

    for (genvar g = 0; g < ENTRIES; g++) begin : g_match
        assign hit_vec[g] = s_q.vld[g] && (s_q.vpn[g] == lk_vpn_i)
                            && (s_q.asid[g] == lk_asid_i);
    end

    always_comb begin
        logic [PFN_W-1:0] pfn_acc;
        logic [2:0]       perm_acc;
        pfn_acc  = '0;
        perm_acc = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (hit_vec[i]) begin
                pfn_acc  = pfn_acc | s_q.pfn[i];
                perm_acc = perm_acc | s_q.perm[i];
            end
        end
        lk_hit_o  = |hit_vec;
        lk_pfn_o  = pfn_acc;
        lk_perm_o = perm_t'(perm_acc);
    end

    always_comb begin
        s_d = s_q;
        if (ins_en_i) begin
            s_d.vld[ins_idx_i]  = 1'b1;
            s_d.vpn[ins_idx_i]  = ins_vpn_i;
            s_d.pfn[ins_idx_i]  = ins_pfn_i;
            s_d.asid[ins_idx_i] = ins_asid_i;
            s_d.perm[ins_idx_i] = ins_perm_i;
        end
        if (flush_all_i) begin
            s_d.vld = '0;
        end else if (flush_asid_en_i) begin
            for (int i = 0; i < ENTRIES; i++) begin
                if (s_d.asid[i] == flush_asid_i) s_d.vld[i] = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign valid_o = s_q.vld;

    // R3: a lookup never matches two slots
    a_r3_one_match: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit_vec));

    // R10: a full flush leaves no slot valid
    a_r10_flush_empty: assert property (@(posedge clk) disable iff (!rst_n)
        flush_all_i |=> (s_q.vld == '0));

    for (genvar g = 0; g < ENTRIES; g++) begin : g_chk
        // R11: no slot of the flushed ASID survives
        a_r11_asid_clear: assert property (@(posedge clk) disable iff (!rst_n)
            flush_asid_en_i |=> !(s_q.vld[g] && (s_q.asid[g] == $past(flush_asid_i))));
    end

endmodule

// File: rtl/tlb_asid_refill.sv
module tlb_asid_refill
    import tlb_pkg::*;
#(
    parameter int VA_W       = 16,
    parameter int PAGE_BYTES = 256,
    parameter int PFN_W      = 8,
    parameter int ASID_W     = 8,
    parameter int ENTRIES    = 8,
    parameter int PTE_BYTES  = 4,
    localparam int OFF_W     = $clog2(PAGE_BYTES),
    localparam int VPN_W     = VA_W - OFF_W,
    localparam int PA_W      = PFN_W + OFF_W,
    localparam int PTE_SH    = $clog2(PTE_BYTES),
    localparam int IDX_W     = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [VA_W-1:0]   req_vaddr,
    input  logic [1:0]        req_acc,
    input  logic [ASID_W-1:0] req_asid,
    input  logic [PA_W-1:0]   ptbr,
    input  logic              flush_all,
    input  logic              flush_asid_en,
    input  logic [ASID_W-1:0] flush_asid,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic [PA_W-1:0]   mem_req_addr,
    input  logic              mem_rsp_valid,
    input  logic [31:0]       mem_rsp_data,
    output logic              rsp_valid,
    output logic [1:0]        rsp_status,
    output logic [PA_W-1:0]   rsp_paddr
);

    typedef struct packed {
        fsm_e              fsm;
        logic [VPN_W-1:0]  vpn;
        logic [1:0]        acc;
        logic [ASID_W-1:0] asid;
        logic              rv;
        logic [1:0]        rs;
        logic [PA_W-1:0]   rpa;
    } top_t;

    top_t               s_d, s_q;

    logic               lk_hit;
    logic [PFN_W-1:0]   lk_pfn;
    perm_t              lk_perm;
    logic               ins_en;
    logic [IDX_W-1:0]   victim;
    logic [ENTRIES-1:0] cam_valid;

    logic               pte_v;
    perm_t              pte_perm;
    logic [PFN_W-1:0]   pte_pfn;
    logic               unused_pte_bits;

    assign pte_v           = mem_rsp_data[31];
    assign pte_perm        = perm_t'(mem_rsp_data[30:28]);
    assign pte_pfn         = mem_rsp_data[PFN_W-1:0];
    assign unused_pte_bits = ^mem_rsp_data[27:PFN_W];

    tlb_cam #(
        .ENTRIES (ENTRIES),
        .VPN_W   (VPN_W),
        .PFN_W   (PFN_W),
        .ASID_W  (ASID_W)
    ) u_cam (
        .clk             (clk),
        .rst_n           (rst_n),
        .lk_vpn_i        (req_vaddr[VA_W-1:OFF_W]),
        .lk_asid_i       (req_asid),
        .lk_hit_o        (lk_hit),
        .lk_pfn_o        (lk_pfn),
        .lk_perm_o       (lk_perm),
        .flush_all_i     (flush_all),
        .flush_asid_en_i (flush_asid_en),
        .flush_asid_i    (flush_asid),
        .ins_en_i        (ins_en),
        .ins_idx_i       (victim),
        .ins_vpn_i       (s_q.vpn),
        .ins_pfn_i       (pte_pfn),
        .ins_perm_i      (pte_perm),
        .ins_asid_i      (s_q.asid),
        .valid_o         (cam_valid)
    );

    tlb_victim_sel #(
        .ENTRIES (ENTRIES)
    ) u_victim (
        .clk      (clk),
        .rst_n    (rst_n),
        .valid_i  (cam_valid),
        .alloc_i  (ins_en),
        .victim_o (victim)
    );

    always_comb begin
        s_d       = s_q;
        s_d.rv    = 1'b0;
        s_d.rs    = RS_OK;
        s_d.rpa   = '0;
        ins_en    = 1'b0;
        req_ready = (s_q.fsm == FS_IDLE) && !flush_all && !flush_asid_en;
        mem_req_valid = (s_q.fsm == FS_FETCH);
        mem_req_addr  = ptbr + (PA_W'(s_q.vpn) << PTE_SH);

        case (s_q.fsm)
            FS_IDLE: begin
                if (req_valid && req_ready) begin
                    if (lk_hit) begin
                        s_d.rv = 1'b1;
                        if (perm_ok(lk_perm, req_acc)) begin
                            s_d.rs  = RS_OK;
                            s_d.rpa = {lk_pfn, req_vaddr[OFF_W-1:0]};
                        end else begin
                            s_d.rs  = RS_PROT;
                        end
                    end else begin
                        s_d.fsm  = FS_FETCH;
                        s_d.vpn  = req_vaddr[VA_W-1:OFF_W];
                        s_d.acc  = req_acc;
                        s_d.asid = req_asid;
                    end
                end
            end
            FS_FETCH: begin
                if (mem_req_ready) s_d.fsm = FS_WAIT;
            end
            FS_WAIT: begin
                if (mem_rsp_valid) begin
                    s_d.fsm = FS_IDLE;
                    s_d.rv  = 1'b1;
                    if (!pte_v) begin
                        s_d.rs = RS_SEGV;
                    end else if (!perm_ok(pte_perm, s_q.acc)) begin
                        s_d.rs = RS_PROT;
                    end else begin
                        ins_en = 1'b1;
                        s_d.rs = RS_RETRY;
                    end
                end
            end
            default: s_d.fsm = FS_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign rsp_valid  = s_q.rv;
    assign rsp_status = s_q.rs;
    assign rsp_paddr  = s_q.rpa;

    // R5: a pending table read keeps its address until taken
    a_r5_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

    // R4: a faulting response carries no physical address
    a_r4_fault_no_pa: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && (rsp_status != RS_OK)) |-> (rsp_paddr == '0));

    // R9: while a slot is empty, a refill never overwrites a live one
    a_r9_free_first: assert property (@(posedge clk) disable iff (!rst_n)
        (ins_en && !(&cam_valid)) |-> !cam_valid[victim]);

endmodule

// File: tb/tlb_asid_refill_tb.sv
module tlb_asid_refill_tb;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid;
    logic        req_ready;
    logic [15:0] req_vaddr;
    logic [1:0]  req_acc;
    logic [7:0]  req_asid;
    logic [15:0] ptbr;
    logic        flush_all;
    logic        flush_asid_en;
    logic [7:0]  flush_asid;
    logic        mem_req_valid;
    logic        mem_req_ready;
    logic [15:0] mem_req_addr;
    logic        mem_rsp_valid;
    logic [31:0] mem_rsp_data;
    logic        rsp_valid;
    logic [1:0]  rsp_status;
    logic [15:0] rsp_paddr;

    localparam logic [15:0] PT_BASE = 16'h4000;

    int n_tests = 0;
    int n_fail  = 0;
    int mem_reads = 0;
    int last_addr = 0;
    int mem_cd = 0;
    int mem_vpn = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    tlb_asid_refill u_dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .req_valid     (req_valid),
        .req_ready     (req_ready),
        .req_vaddr     (req_vaddr),
        .req_acc       (req_acc),
        .req_asid      (req_asid),
        .ptbr          (ptbr),
        .flush_all     (flush_all),
        .flush_asid_en (flush_asid_en),
        .flush_asid    (flush_asid),
        .mem_req_valid (mem_req_valid),
        .mem_req_ready (mem_req_ready),
        .mem_req_addr  (mem_req_addr),
        .mem_rsp_valid (mem_rsp_valid),
        .mem_rsp_data  (mem_rsp_data),
        .rsp_valid     (rsp_valid),
        .rsp_status    (rsp_status),
        .rsp_paddr     (rsp_paddr)
    );

    function automatic logic [31:0] pte_of(int v);
        logic [7:0] b;
        b = v[7:0];
        return {(b[2:0] != 3'd7), b[5], b[4], b[3], 20'd0, b ^ 8'hC3};
    endfunction

    function automatic bit allowed(int v, int acc);
        logic [7:0] b;
        b = v[7:0];
        case (acc)
            0: return b[5];
            1: return b[4];
            2: return b[3];
            default: return 1'b0;
        endcase
    endfunction

    function automatic int good_vpn(int k);
        return (k < 7) ? (32'h20 + k) : (32'h30 + k - 7);
    endfunction

    // memory model: one accepted read, data two negedges later
    always @(negedge clk) begin
        mem_rsp_valid = 1'b0;
        if (mem_cd > 0) begin
            mem_cd--;
            if (mem_cd == 0) begin
                mem_rsp_valid = 1'b1;
                mem_rsp_data  = pte_of(mem_vpn);
            end
        end
        if (mem_req_valid) begin
            mem_reads++;
            last_addr = int'(mem_req_addr);
            mem_vpn   = (int'(mem_req_addr) - int'(PT_BASE)) >>> 2;
            mem_cd    = 2;
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    endtask

    task automatic do_req(input int vpn, input int off, input int acc, input int asid,
                          output int st, output int pa, output int rd, output int lat);
        int r0;
        r0        = mem_reads;
        req_vaddr = {vpn[7:0], off[7:0]};
        req_acc   = acc[1:0];
        req_asid  = asid[7:0];
        req_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        lat = 1;
        while (!rsp_valid && lat < 200) begin
            @(negedge clk);
            lat++;
        end
        st = int'(rsp_status);
        pa = int'(rsp_paddr);
        rd = mem_reads - r0;
    endtask

    task automatic flush_everything();
        flush_all = 1'b1;
        #1;
        chk("R10 ready low during flush", int'(req_ready), 0);
        @(negedge clk);
        flush_all = 1'b0;
    endtask

    task automatic install(input int vpn, input int asid, input string tag);
        int st, pa, rd, lat;
        do_req(vpn, 0, 0, asid, st, pa, rd, lat);
        chk({tag, " install status"}, st, 1);
        chk({tag, " install reads"}, rd, 1);
    endtask

    task automatic probe(input int vpn, input int asid, input int exp_rd, input string tag);
        int st, pa, rd, lat;
        do_req(vpn, 8'h5A, 0, asid, st, pa, rd, lat);
        chk({tag, " reads"}, rd, exp_rd);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        int st, pa, rd, lat;
        int acc, off, exp_st;
        rst_n         = 1'b0;
        req_valid     = 1'b0;
        req_vaddr     = '0;
        req_acc       = '0;
        req_asid      = '0;
        ptbr          = PT_BASE;
        flush_all     = 1'b0;
        flush_asid_en = 1'b0;
        flush_asid    = '0;
        mem_req_ready = 1'b1;
        mem_rsp_valid = 1'b0;
        mem_rsp_data  = '0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R12: reset state
        chk("R12 req_ready", int'(req_ready), 1);
        chk("R12 rsp_valid", int'(rsp_valid), 0);
        chk("R12 mem_req_valid", int'(mem_req_valid), 0);

        // sweep over every page and every access kind
        for (int v = 0; v < 256; v++) begin
            flush_everything();
            acc = v % 4;
            off = (v * 37 + 11) & 255;
            if (pte_of(v)[31] == 1'b0)  exp_st = 2;
            else if (!allowed(v, acc))  exp_st = 3;
            else                        exp_st = 1;

            do_req(v, off, acc, 5, st, pa, rd, lat);
            chk("R5 miss read count", rd, 1);
            chk("R5 table address", last_addr, int'(PT_BASE) + 4 * v);
            chk("R6 R7 R8 miss status", st, exp_st);

            do_req(v, off, acc, 5, st, pa, rd, lat);
            if (exp_st == 1) begin
                chk("R8 retry then hit status", st, 0);
                chk("R1 physical address", pa, {(v ^ 32'hC3) & 255, off[7:0]});
                chk("R2 hit reads", rd, 0);
                chk("R2 hit latency", lat, 1);
                for (int a2 = 0; a2 < 4; a2++) begin
                    if (a2 != acc) begin
                        do_req(v, off, a2, 5, st, pa, rd, lat);
                        chk("R4 hit reads", rd, 0);
                        chk("R4 hit status", st, allowed(v, a2) ? 0 : 3);
                        chk("R4 hit address", pa,
                            allowed(v, a2) ? {(v ^ 32'hC3) & 255, off[7:0]} : 0);
                    end
                end
            end else if (exp_st == 2) begin
                chk("R6 segv not cached reads", rd, 1);
                chk("R6 segv repeat status", st, 2);
            end else begin
                chk("R7 prot not cached reads", rd, 1);
                chk("R7 prot repeat status", st, 3);
            end
        end

        // R3: same page, different ASID misses
        flush_everything();
        install(good_vpn(0), 11, "R3");
        probe(good_vpn(0), 12, 1, "R3 other asid misses");
        probe(good_vpn(0), 11, 0, "R3 own asid hits");
        probe(good_vpn(0), 12, 0, "R3 second asid now cached");

        // R9: fill, then round-robin eviction from slot 0
        flush_everything();
        for (int k = 0; k < 8; k++) install(good_vpn(k), 7, "R9 fill");
        for (int k = 0; k < 8; k++) probe(good_vpn(k), 7, 0, "R9 all resident");
        install(good_vpn(8), 7, "R9 ninth");
        probe(good_vpn(1), 7, 0, "R9 slot1 kept");
        probe(good_vpn(0), 7, 1, "R9 slot0 evicted");
        probe(good_vpn(8), 7, 0, "R9 ninth resident");
        probe(good_vpn(1), 7, 1, "R9 slot1 evicted next");

        // R11: flush by ASID
        flush_everything();
        install(good_vpn(0), 3, "R11");
        install(good_vpn(1), 4, "R11");
        flush_asid    = 8'd3;
        flush_asid_en = 1'b1;
        #1;
        chk("R10 ready low during asid flush", int'(req_ready), 0);
        @(negedge clk);
        flush_asid_en = 1'b0;
        probe(good_vpn(1), 4, 0, "R11 other asid kept");
        probe(good_vpn(0), 3, 1, "R11 flushed asid misses");

        // R10: flush all
        flush_everything();
        install(good_vpn(2), 1, "R10");
        install(good_vpn(3), 1, "R10");
        flush_everything();
        probe(good_vpn(2), 1, 1, "R10 first gone");
        probe(good_vpn(3), 1, 1, "R10 second gone");

        finish_run();
    end

endmodule